// File: doc/BRIEF.md
# Transmit Clock Loss Monitor

This block watches one channel's transmit clock against a free-running master clock. The transmit clock goes through a two-stage synchronizer into the master domain. There, any level change resets an idle counter. When the count runs past a threshold, a loss status bit is set. The bit clears by itself as soon as transmit clock activity comes back. The rising edge of the status latches an interrupt, which can be masked and is cleared by a write-one-to-clear pulse.

The block also picks the reference for internally generated transmit patterns, either the transmit clock or the master clock. It emits the matching clock enable and a sample strobe on whichever transmit clock edge is configured. It also decides whether the line driver stays enabled.

A second, faster check clock watches the master clock itself, because the master clock cannot detect its own absence. If the master clock stops, the driver is forced off whatever the transmit clock is doing.

Top module: `txclk_loss_mon`

## Requirements
- R1: `tx_loss_stat` becomes 1 only after more than `IDLE_LIMIT` (default 70) consecutive master clock cycles in which the synchronized transmit clock shows no level change. It stays 0 while the transmit clock keeps toggling.
- R2: `tx_loss_stat` returns to 0 without any software action once a transmit clock level change is seen again.
- R3: `pat_ref_mclk` is 1 when `auto_ones` or `ais_en` is 1, whatever `pat_sel_mclk` is. Otherwise it equals `pat_sel_mclk` (1 = master clock reference, 0 = transmit clock reference).
- R4: `pat_clk_en` is 1 in every master clock cycle when `pat_ref_mclk` is 1. Otherwise it equals `tx_sample_stb`.
- R5: While the master clock runs, `drv_en` is 0 exactly when `tx_loss_stat` is 1 and the channel is neither in remote loopback (`rem_loop`=1) nor sending an internal pattern (`pat_active`=1) with `pat_ref_mclk`=1.
- R6: If the master clock stops toggling for more than `REF_LIMIT` check clock cycles, `drv_en` is 0 regardless of every other input. It returns to 1 after the master clock resumes.
- R7: A rising edge of `tx_loss_stat` sets `irq` when `irq_mask` is 0. `irq` stays set until `irq_clr` is 1. A new loss edge in the same cycle as `irq_clr` wins, and `irq` remains 1. With `irq_mask` at 1, a loss leaves `irq` at 0.
- R8: `tx_sample_stb` pulses once for each rising transmit clock edge when `edge_sel` is 0, and once for each falling edge when `edge_sel` is 1. It does not pulse on the other edge.
- R9: After reset, `tx_loss_stat` and `irq` are 0 and `drv_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Free-running master reference clock |
| chk_clk | input | 1 | Independent check clock used to supervise mclk |
| rst | input | 1 | Synchronous active-high reset |
| tclk | input | 1 | Transmit clock (asynchronous) |
| edge_sel | input | 1 | 0 = sample on rising transmit edge, 1 = falling |
| pat_sel_mclk | input | 1 | Pattern reference select, 1 = master clock |
| auto_ones | input | 1 | Automatic all-ones mode active |
| ais_en | input | 1 | Alarm-indication-send mode active |
| rem_loop | input | 1 | Channel in remote loopback |
| pat_active | input | 1 | Internal pattern being sent |
| irq_mask | input | 1 | Masks the loss interrupt |
| irq_clr | input | 1 | Write-one-to-clear pulse for irq |
| tx_loss_stat | output | 1 | Transmit clock loss status |
| irq | output | 1 | Latched loss interrupt |
| pat_ref_mclk | output | 1 | 1 when patterns use the master clock |
| pat_clk_en | output | 1 | Pattern clock enable in the master domain |
| tx_sample_stb | output | 1 | Strobe on the selected transmit clock edge |
| drv_en | output | 1 | Line driver enable (0 = high impedance) |

## Verification
The interrupt latch can see a loss edge and a clear pulse in the same cycle. The bench provokes this by stopping the transmit clock and watching the loss status at each falling master edge. In the first cycle the status is seen high, it drives `irq_clr` before the next rising edge, so the latch's set and clear arrive together. It then checks that `irq` is still 1, and that a lone clear pulse afterwards drops it to 0.

// File: rtl/txclk_mon_pkg.sv
`timescale 1ns/1ps
package txclk_mon_pkg;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    typedef struct packed {
        logic sel_mclk;
        logic auto_ones;
        logic ais;
    } pat_cfg_t;

    typedef struct packed {
        logic rem_loop;
        logic pat_active;
    } drv_cfg_t;

    // Forced modes override the software select
    function automatic logic pat_uses_mclk(pat_cfg_t c);
        return c.sel_mclk | c.auto_ones | c.ais;
    endfunction

    // Driver stays on unless a clock is missing and nothing keeps it alive
    function automatic logic drv_keep(logic tx_lost, logic ref_lost,
                                      drv_cfg_t d, logic pat_mclk);
        logic exempt;
        exempt = d.rem_loop | (d.pat_active & pat_mclk);
        return ~ref_lost & (~tx_lost | exempt);
    endfunction

endpackage

// File: rtl/tx_activity_mon.sv
`timescale 1ns/1ps
module tx_activity_mon
    import txclk_mon_pkg::*;
#(
    parameter int IDLE_LIMIT  = 70,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tclk_async,
    input  edge_sel_e edge_sel,
    output logic      tx_lost,
    output logic      lost_set,
    output logic      smp_stb
);
    localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
    localparam int SH_W  = SYNC_STAGES + 1;

    logic [SH_W-1:0]  sh;
    logic [CNT_W-1:0] idle_cnt;
    logic             cur, prv, any_edge, sel_edge;

    assign cur      = sh[SYNC_STAGES-1];
    assign prv      = sh[SYNC_STAGES];
    assign any_edge = cur ^ prv;
    assign sel_edge = (edge_sel == EDGE_RISE) ? (cur & ~prv) : (~cur & prv);

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SH_W-2:0], tclk_async};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
            tx_lost  <= 1'b0;
            lost_set <= 1'b0;
        end else if (any_edge) begin
            idle_cnt <= '0;
            tx_lost  <= 1'b0;
            lost_set <= 1'b0;
        end else if (idle_cnt == CNT_W'(IDLE_LIMIT)) begin
            tx_lost  <= 1'b1;
            lost_set <= ~tx_lost;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
            lost_set <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) smp_stb <= 1'b0;
        else     smp_stb <= sel_edge;
    end

    // R1
    lost_after_limit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_lost) |-> $past(idle_cnt) == CNT_W'(IDLE_LIMIT));
    // R2
    edge_clears_chk: assert property (@(posedge clk) disable iff (rst)
        any_edge |=> !tx_lost);

endmodule

// File: rtl/ref_clk_watch.sv
`timescale 1ns/1ps
module ref_clk_watch #(
    parameter int REF_LIMIT   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic chk_clk,
    input  logic rst,
    input  logic ref_async,
    output logic ref_lost
);
    localparam int CNT_W = $clog2(REF_LIMIT + 1);
    localparam int SH_W  = SYNC_STAGES + 1;

    logic [SH_W-1:0]  sh;
    logic [CNT_W-1:0] cnt;
    logic             toggled;

    assign toggled = sh[SYNC_STAGES-1] ^ sh[SYNC_STAGES];

    always_ff @(posedge chk_clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SH_W-2:0], ref_async};
    end

    always_ff @(posedge chk_clk) begin
        if (rst) begin
            cnt      <= '0;
            ref_lost <= 1'b0;
        end else if (toggled) begin
            cnt      <= '0;
            ref_lost <= 1'b0;
        end else if (cnt == CNT_W'(REF_LIMIT)) begin
            ref_lost <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6
    ref_lost_limit_chk: assert property (@(posedge chk_clk) disable iff (rst)
        $rose(ref_lost) |-> $past(cnt) == CNT_W'(REF_LIMIT));

endmodule

// File: rtl/loss_irq_latch.sv
`timescale 1ns/1ps
module loss_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic mask,
    input  logic clr,
    output logic irq_q
);
    logic set_pend;
    assign set_pend = set_evt & ~mask;

    always_ff @(posedge clk) begin
        if (rst)           irq_q <= 1'b0;
        else if (set_pend) irq_q <= 1'b1;
        else if (clr)      irq_q <= 1'b0;
    end

    // R7
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_pend |=> irq_q);
    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !clr) |=> irq_q);

endmodule

// File: rtl/txclk_loss_mon.sv
`timescale 1ns/1ps
module txclk_loss_mon
    import txclk_mon_pkg::*;
#(
    parameter int IDLE_LIMIT  = 70,
    parameter int REF_LIMIT   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic mclk,
    input  logic chk_clk,
    input  logic rst,
    input  logic tclk,
    input  logic edge_sel,
    input  logic pat_sel_mclk,
    input  logic auto_ones,
    input  logic ais_en,
    input  logic rem_loop,
    input  logic pat_active,
    input  logic irq_mask,
    input  logic irq_clr,
    output logic tx_loss_stat,
    output logic irq,
    output logic pat_ref_mclk,
    output logic pat_clk_en,
    output logic tx_sample_stb,
    output logic drv_en
);
    pat_cfg_t  pcfg;
    drv_cfg_t  dcfg;
    edge_sel_e esel;
    logic      lost_set, ref_lost;

    assign pcfg = '{sel_mclk: pat_sel_mclk, auto_ones: auto_ones, ais: ais_en};
    assign dcfg = '{rem_loop: rem_loop, pat_active: pat_active};
    assign esel = edge_sel_e'(edge_sel);

    tx_activity_mon #(
        .IDLE_LIMIT (IDLE_LIMIT),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_act (
        .clk       (mclk),
        .rst       (rst),
        .tclk_async(tclk),
        .edge_sel  (esel),
        .tx_lost   (tx_loss_stat),
        .lost_set  (lost_set),
        .smp_stb   (tx_sample_stb)
    );

    ref_clk_watch #(
        .REF_LIMIT  (REF_LIMIT),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_ref (
        .chk_clk  (chk_clk),
        .rst      (rst),
        .ref_async(mclk),
        .ref_lost (ref_lost)
    );

    loss_irq_latch u_irq (
        .clk    (mclk),
        .rst    (rst),
        .set_evt(lost_set),
        .mask   (irq_mask),
        .clr    (irq_clr),
        .irq_q  (irq)
    );

    assign pat_ref_mclk = pat_uses_mclk(pcfg);
    assign pat_clk_en   = pat_ref_mclk ? 1'b1 : tx_sample_stb;
    assign drv_en       = drv_keep(tx_loss_stat, ref_lost, dcfg, pat_ref_mclk);

    // R3
    forced_ref_chk: assert property (@(posedge mclk) disable iff (rst)
        (auto_ones || ais_en) |-> pat_ref_mclk);
    // R6
    ref_off_chk: assert property (@(posedge chk_clk) disable iff (rst)
        ref_lost |-> !drv_en);
    // R5
    loop_keeps_drv_chk: assert property (@(posedge mclk) disable iff (rst)
        (rem_loop && !ref_lost) |-> drv_en);

endmodule

// File: tb/txclk_loss_mon_bench.sv
`timescale 1ns/1ps
module txclk_loss_mon_bench;
    logic mclk = 1'b0, chk_clk = 1'b0, rst = 1'b1;
    logic tclk = 1'b0, tclk_run = 1'b0, tclk_force = 1'b0, mclk_run = 1'b1;
    logic edge_sel = 0, pat_sel_mclk = 0, auto_ones = 0, ais_en = 0;
    logic rem_loop = 0, pat_active = 0, irq_mask = 0, irq_clr = 0;
    logic tx_loss_stat, irq, pat_ref_mclk, pat_clk_en, tx_sample_stb, drv_en;
    int   tdiv = 0;
    int   checks = 0, errors = 0;

    always begin
        #10;
        if (mclk_run) mclk = ~mclk;
    end
    always #3 chk_clk = ~chk_clk;

    always @(negedge mclk) begin
        if (tclk_run) begin
            if (tdiv == 2) begin tclk <= ~tclk; tdiv <= 0; end
            else tdiv <= tdiv + 1;
        end else tclk <= tclk_force;
    end

    txclk_loss_mon u_txclk_loss_mon (
        .mclk(mclk), .chk_clk(chk_clk), .rst(rst), .tclk(tclk),
        .edge_sel(edge_sel), .pat_sel_mclk(pat_sel_mclk), .auto_ones(auto_ones),
        .ais_en(ais_en), .rem_loop(rem_loop), .pat_active(pat_active),
        .irq_mask(irq_mask), .irq_clr(irq_clr), .tx_loss_stat(tx_loss_stat),
        .irq(irq), .pat_ref_mclk(pat_ref_mclk), .pat_clk_en(pat_clk_en),
        .tx_sample_stb(tx_sample_stb), .drv_en(drv_en)
    );

    function automatic logic exp_ref(logic s, logic a, logic i);
        return s | a | i;
    endfunction
    function automatic logic exp_drv(logic lost, logic lp, logic pa, logic rm);
        return ~lost | lp | (pa & rm);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge mclk);
    endtask

    task automatic rand_cfg();
        pat_sel_mclk = 1'($urandom);
        auto_ones    = 1'(($urandom % 4) == 0);
        ais_en       = 1'(($urandom % 4) == 0);
        rem_loop     = 1'($urandom);
        pat_active   = 1'($urandom);
    endtask

    task automatic clear_cfg();
        pat_sel_mclk = 0; auto_ones = 0; ais_en = 0; rem_loop = 0; pat_active = 0;
    endtask

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int stb_n;
        logic seen;
        void'($urandom(32'd4242));
        cyc(5);
        rst = 0;
        cyc(1);
        // R9 reset state
        check("R9 loss", tx_loss_stat, 0);
        check("R9 irq", irq, 0);
        check("R9 drv", drv_en, 1);

        tclk_run = 1;
        cyc(100);
        check("R1 no false loss", tx_loss_stat, 0);

        // R3 R4 R5 random config with clock present
        for (int k = 0; k < 40; k++) begin
            rand_cfg();
            cyc(1);
            check("R3 ref", pat_ref_mclk, exp_ref(pat_sel_mclk, auto_ones, ais_en));
            check("R5 drv ok", drv_en, exp_drv(0, rem_loop, pat_active,
                                              exp_ref(pat_sel_mclk, auto_ones, ais_en)));
            for (int j = 0; j < 6; j++) begin
                cyc(1);
                check("R4 pat en", pat_clk_en,
                      exp_ref(pat_sel_mclk, auto_ones, ais_en) ? 1 : tx_sample_stb);
            end
        end

        // R1 R7 loss with clear in the same cycle
        clear_cfg();
        tclk_force = tclk;
        tclk_run = 0;
        cyc(60);
        check("R1 not yet lost", tx_loss_stat, 0);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge mclk);
            irq_clr = 0;
            if (tx_loss_stat && !seen) begin
                seen = 1;
                irq_clr = 1;
            end
        end
        irq_clr = 0;
        check("R1 lost", tx_loss_stat, 1);
        check("R7 set beats clear", irq, 1);
        check("R5 drv off", drv_en, 0);
        for (int k = 0; k < 20; k++) begin
            rand_cfg();
            cyc(1);
            check("R5 drv lost", drv_en, exp_drv(1, rem_loop, pat_active,
                                               exp_ref(pat_sel_mclk, auto_ones, ais_en)));
        end
        clear_cfg();
        irq_clr = 1;
        cyc(1);
        irq_clr = 0;
        cyc(1);
        check("R7 cleared", irq, 0);

        // R2 recovery
        tclk_run = 1;
        cyc(10);
        check("R2 loss cleared", tx_loss_stat, 0);
        check("R2 drv back", drv_en, 1);

        // R7 masked
        irq_mask = 1;
        tclk_force = tclk;
        tclk_run = 0;
        cyc(90);
        check("R7 masked loss", tx_loss_stat, 1);
        check("R7 masked irq", irq, 0);
        tclk_run = 1;
        cyc(10);
        irq_mask = 0;
        check("R2 loss cleared again", tx_loss_stat, 0);

        // R8 edge select
        for (int e = 0; e < 2; e++) begin
            edge_sel = 1'(e);
            tclk_run = 0;
            tclk_force = 0;
            cyc(6);
            tclk_force = 1;
            stb_n = 0;
            for (int i = 0; i < 6; i++) begin cyc(1); stb_n += tx_sample_stb; end
            check("R8 rise", stb_n, (e == 0) ? 1 : 0);
            tclk_force = 0;
            stb_n = 0;
            for (int i = 0; i < 6; i++) begin cyc(1); stb_n += tx_sample_stb; end
            check("R8 fall", stb_n, (e == 1) ? 1 : 0);
        end
        edge_sel = 0;
        tclk_run = 1;
        cyc(10);

        // R6 master clock stop
        rem_loop = 1;
        mclk_run = 0;
        #300;
        check("R6 drv off", drv_en, 0);
        mclk_run = 1;
        cyc(10);
        check("R6 drv restored", drv_en, 1);
        rem_loop = 0;
        cyc(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule